// File: doc/BRIEF.md
# Late-Write Synchronous Burst SRAM Core

This block is a synthesizable synchronous SRAM with no bus turnaround penalty. Address, commands, byte-write enables and write data are all sampled on the rising clock edge. The write data of a command arrives late, in the same cycle the read data of that command would have appeared. Because of this, reads and writes can follow each other in any order on consecutive edges and the data bus never has to idle.

A static mode pin picks one of two read paths. In pipelined mode the read data passes through an output register. In flow-through mode it comes straight from the array. Bursts of four beats step the two low address bits in either linear or interleaved order. Three chip enables allow depth expansion. An asynchronous output enable and an asynchronous sleep input mask the data outputs. A clock enable freezes every stage. The data bus is modelled as a value `q` and a separate drive flag `q_drive`, with `q` reading zero whenever the bus is not driven.

Top module: `nbt_sram_core`

## Requirements
- R1: When `clk_en` is high, `sleep` is low and `adv` is low, a command is captured at a rising edge only if `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. It is a write when `wr_en`=1 and a read when `wr_en`=0. It starts a burst at `addr`.
- R2: With `pipe_mode`=1, the read data of a command captured at edge n is driven after edge n+1. The write data of a command captured at edge n is sampled from `wdata` at edge n+2.
- R3: With `pipe_mode`=0, the read data of a command captured at edge n is driven after edge n (straight from the array). The write data is sampled at edge n+1.
- R4: Reads and writes may be issued on every edge in any order. A read returns the data of every write commanded before it, including a write on the immediately preceding edge whose data has not yet been stored.
- R5: `bwe_n[b]`, sampled with the command beat, enables the write of bits [9b+8:9b] when low. A lane whose enable is high keeps its old contents.
- R6: With `adv` low and any chip enable inactive, the edge is a deselect. No access takes place, `q_drive` stays low in that slot, and any burst ends.
- R7: With `adv` high, the previous operation continues to the next burst address. The chip enables and `wr_en` are ignored on that edge. An advance after a deselect performs no access.
- R8: Beat k of a burst (k = 0..3, wrapping) keeps the upper address bits of the start address. With `burst_ilv`=0 the two low bits are start+k mod 4. With `burst_ilv`=1 they are start XOR k.
- R9: While `out_en` is low, `q_drive` is low and `q` is zero at once, without waiting for a clock.
- R10: While `sleep` is high, `q_drive` is low at once and any command at that edge is ignored, with the burst position kept. Write data already in flight still lands.
- R11: While `clk_en` is low, no stage advances, nothing is written and the outputs hold their values.
- R12: After reset no read is pending and `q_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en | input | 1 | Clock enable; low freezes all stages |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| burst_ilv | input | 1 | Static: 1 interleaved burst order, 0 linear |
| sleep | input | 1 | Asynchronous power-down; blocks new commands |
| out_en | input | 1 | Asynchronous output enable, active high |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Burst advance |
| wr_en | input | 1 | 1 write, 0 read, for a new command |
| bwe_n | input | NB | Byte-write enables, active low, one per 9-bit lane |
| addr | input | AW | Word address |
| wdata | input | NB*9 | Late write data |
| q | output | NB*9 | Read data, zero when not driven |
| q_drive | output | 1 | High when the block drives the data bus |

## Verification
The bench counts enabled rising edges and keeps every captured command in a history. The read data of the command at history index e is due when e + 2 edges have passed in pipelined mode and e + 1 edges in flow-through mode. The write data of that command is driven in the same slot. Outputs are sampled on the falling edge before new inputs are applied. The expected value is therefore the one due after the last enabled edge, and a frozen cycle leaves that index unchanged. The reference memory is updated at command time, so each read's expectation already includes every earlier write. The async masks are judged against the `out_en` and `sleep` levels present at the sampling instant.

// File: rtl/nbt_sram_pkg.sv
`timescale 1ns/1ps
package nbt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits of a burst beat.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction

  function automatic logic chip_selected(input logic a_n,
                                         input logic b,
                                         input logic c_n);
    return !a_n && b && !c_n;
  endfunction

endpackage

// File: rtl/nbt_cmd_front.sv
`timescale 1ns/1ps
module nbt_cmd_front
  import nbt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          sleep,
  input  logic          burst_ilv,
  input  logic          ce_a_n,
  input  logic          ce_b,
  input  logic          ce_c_n,
  input  logic          adv,
  input  logic          wr_en,
  input  logic [NB-1:0] bwe_n,
  input  logic [AW-1:0] addr,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output logic [NB-1:0] s1_ben_n,
  output logic          new_cmd,
  output logic          burst_step
);

  op_e           burst_op;
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    cnt_nxt;
  logic          accept;
  logic          selected;

  assign accept     = clk_en && !sleep;
  assign selected   = chip_selected(ce_a_n, ce_b, ce_c_n);
  assign new_cmd    = accept && !adv && selected;
  assign burst_step = accept && adv && (burst_op != OP_IDLE);
  assign cnt_nxt    = cnt + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_op <= OP_IDLE;
      base     <= '0;
      cnt      <= '0;
      s1_op    <= OP_IDLE;
      s1_addr  <= '0;
      s1_ben_n <= '1;
    end else if (clk_en) begin
      s1_ben_n <= bwe_n;
      if (sleep) begin
        s1_op <= OP_IDLE;
      end else if (adv) begin
        s1_op <= burst_op;
        if (burst_op != OP_IDLE) begin
          cnt     <= cnt_nxt;
          s1_addr <= {base[AW-1:2], burst_low(base[1:0], cnt_nxt, burst_ilv)};
        end
      end else if (selected) begin
        base     <= addr;
        cnt      <= '0;
        s1_addr  <= addr;
        s1_op    <= wr_en ? OP_WRITE : OP_READ;
        burst_op <= wr_en ? OP_WRITE : OP_READ;
      end else begin
        s1_op    <= OP_IDLE;
        burst_op <= OP_IDLE;
      end
    end
  end

endmodule

// File: rtl/nbt_byte_array.sv
`timescale 1ns/1ps
module nbt_byte_array #(
  parameter int AW = 6,
  parameter int NB = 8,
  parameter int BW = 9,
  localparam int W     = NB * BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [NB-1:0] wben_n,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !wben_n[b]) lane[waddr] <= wdata[b*BW +: BW];
    end

    assign rdata[b*BW +: BW] = lane[raddr];
  end

endmodule

// File: rtl/nbt_late_path.sv
`timescale 1ns/1ps
module nbt_late_path
  import nbt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 8,
  parameter int BW = 9,
  localparam int W = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          pipe_mode,
  input  op_e           s1_op,
  input  logic [AW-1:0] s1_addr,
  input  logic [NB-1:0] s1_ben_n,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  arr_rdata,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [NB-1:0] arr_wben_n,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          fwd_hit
);

  op_e           s2_op;
  logic [AW-1:0] s2_addr;
  logic [NB-1:0] s2_ben_n;
  logic [W-1:0]  merged;
  logic [W-1:0]  oreg;
  logic          ovalid;
  op_e           wr_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op    <= OP_IDLE;
      s2_addr  <= '0;
      s2_ben_n <= '1;
      oreg     <= '0;
      ovalid   <= 1'b0;
    end else if (clk_en) begin
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_ben_n <= s1_ben_n;
      oreg     <= merged;
      ovalid   <= (s1_op == OP_READ);
    end
  end

  // Late write: stage two in pipelined mode, stage one in flow-through.
  assign wr_op      = pipe_mode ? s2_op : s1_op;
  assign arr_we     = clk_en && (wr_op == OP_WRITE);
  assign arr_waddr  = pipe_mode ? s2_addr : s1_addr;
  assign arr_wben_n = pipe_mode ? s2_ben_n : s1_ben_n;

  // A pipelined read meets the write whose data arrives in this cycle.
  assign fwd_hit = pipe_mode && (s2_op == OP_WRITE) && (s1_op == OP_READ) &&
                   (s2_addr == s1_addr);

  for (genvar b = 0; b < NB; b++) begin : g_fwd
    assign merged[b*BW +: BW] = (fwd_hit && !s2_ben_n[b]) ? wdata[b*BW +: BW]
                                                          : arr_rdata[b*BW +: BW];
  end

  assign rd_data  = pipe_mode ? oreg : arr_rdata;
  assign rd_valid = pipe_mode ? ovalid : (s1_op == OP_READ);

endmodule

// File: rtl/nbt_sram_core.sv
`timescale 1ns/1ps
module nbt_sram_core
  import nbt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 8,
  parameter int BW = 9,
  localparam int W = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          pipe_mode,
  input  logic          burst_ilv,
  input  logic          sleep,
  input  logic          out_en,
  input  logic          ce_a_n,
  input  logic          ce_b,
  input  logic          ce_c_n,
  input  logic          adv,
  input  logic          wr_en,
  input  logic [NB-1:0] bwe_n,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q,
  output logic          q_drive
);

  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic [NB-1:0] s1_ben_n;
  logic          new_cmd;
  logic          burst_step;
  logic          arr_we;
  logic [AW-1:0] arr_waddr;
  logic [NB-1:0] arr_wben_n;
  logic [W-1:0]  arr_rdata;
  logic [W-1:0]  core_rd_data;
  logic          core_rd_valid;
  logic          fwd_hit;

  nbt_cmd_front #(.AW(AW), .NB(NB)) front_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
    .burst_ilv(burst_ilv), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .adv(adv), .wr_en(wr_en), .bwe_n(bwe_n), .addr(addr),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_ben_n(s1_ben_n),
    .new_cmd(new_cmd), .burst_step(burst_step)
  );

  nbt_byte_array #(.AW(AW), .NB(NB), .BW(BW)) array_i (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wben_n(arr_wben_n),
    .wdata(wdata), .raddr(s1_addr), .rdata(arr_rdata)
  );

  nbt_late_path #(.AW(AW), .NB(NB), .BW(BW)) late_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pipe_mode(pipe_mode),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_ben_n(s1_ben_n),
    .wdata(wdata), .arr_rdata(arr_rdata),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wben_n(arr_wben_n),
    .rd_data(core_rd_data), .rd_valid(core_rd_valid), .fwd_hit(fwd_hit)
  );

  // Asynchronous masks on the bus.
  assign q_drive = out_en && !sleep && core_rd_valid;
  assign q       = q_drive ? core_rd_data : '0;

endmodule

// File: rtl/nbt_sram_checks.sv
`timescale 1ns/1ps
module nbt_sram_checks
  import nbt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int W  = 72
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          sleep,
  input logic          pipe_mode,
  input logic          adv,
  input logic          ce_a_n,
  input logic          ce_b,
  input logic          ce_c_n,
  input logic [AW-1:0] addr,
  input op_e           s1_op,
  input logic [AW-1:0] s1_addr,
  input logic          new_cmd,
  input logic          burst_step,
  input logic          fwd_hit,
  input logic          arr_we,
  input logic          core_rd_valid,
  input logic [W-1:0]  core_rd_data
);

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    new_cmd |=> (s1_op != OP_IDLE) && (s1_addr == $past(addr)));

  assert_pipe_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && clk_en && s1_op == OP_READ) |=> core_rd_valid);

  assert_forward_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_hit && clk_en) |=> core_rd_valid);

  assert_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && !adv && (ce_a_n || !ce_b || ce_c_n)) |=> s1_op == OP_IDLE);

  assert_burst_cont_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_step |=> s1_op != OP_IDLE);

  assert_burst_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !sleep && adv) |=> s1_addr[AW-1:2] == $past(s1_addr[AW-1:2]));

  assert_sleep_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sleep) |=> s1_op == OP_IDLE);

  assert_freeze_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !arr_we);

  assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(core_rd_data) && $stable(core_rd_valid));

endmodule

bind nbt_sram_core nbt_sram_checks #(.AW(AW), .W(W)) checks_i (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sleep(sleep),
  .pipe_mode(pipe_mode), .adv(adv), .ce_a_n(ce_a_n), .ce_b(ce_b),
  .ce_c_n(ce_c_n), .addr(addr), .s1_op(s1_op), .s1_addr(s1_addr),
  .new_cmd(new_cmd), .burst_step(burst_step), .fwd_hit(fwd_hit),
  .arr_we(arr_we), .core_rd_valid(core_rd_valid), .core_rd_data(core_rd_data)
);

// File: tb/nbt_sram_core_tb_top.sv
`timescale 1ns/1ps
module nbt_sram_core_tb_top;
  localparam int AW = 6, NB = 8, BW = 9, W = NB * BW, DEPTH = 1 << AW, HMAX = 4096;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, clk_en = 1'b1, pipe_mode = 1'b1, burst_ilv = 1'b0;
  logic sleep = 1'b0, out_en = 1'b1, ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic adv = 1'b0, wr_en = 1'b0;
  logic [NB-1:0] bwe_n = '1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  q;
  logic          q_drive;

  nbt_sram_core #(.AW(AW), .NB(NB), .BW(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pipe_mode(pipe_mode),
    .burst_ilv(burst_ilv), .sleep(sleep), .out_en(out_en), .ce_a_n(ce_a_n),
    .ce_b(ce_b), .ce_c_n(ce_c_n), .adv(adv), .wr_en(wr_en), .bwe_n(bwe_n),
    .addr(addr), .wdata(wdata), .q(q), .q_drive(q_drive)
  );

  int n_vec = 0, n_bad = 0;
  logic [W-1:0] ref_mem [DEPTH];
  int           kind_h [HMAX];   // 0 none, 1 read, 2 write
  logic [W-1:0] exp_h  [HMAX];
  logic [W-1:0] wdat_h [HMAX];
  string        tag_h  [HMAX];
  int  eff = 0, lat = 2, b_op = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;
  bit  prev_frozen = 0;

  // Burst low bits, written arithmetically (R8).
  function automatic logic [1:0] ref_low(logic [1:0] s, logic [1:0] k, bit ilv);
    int v;
    if (ilv) v = ((s[1] != k[1]) ? 2 : 0) + ((s[0] != k[0]) ? 1 : 0);
    else     v = (int'(s) + int'(k)) % 4;
    return 2'(v);
  endfunction

  // Lane merge under active-low enables (R5).
  function automatic logic [W-1:0] ref_merge(logic [W-1:0] old, logic [W-1:0] nw,
                                             logic [NB-1:0] ben);
    logic [W-1:0] r = old;
    for (int b = 0; b < NB; b++)
      if (ben[b] == 1'b0) r[b*BW +: BW] = nw[b*BW +: BW];
    return r;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return W'({$urandom, $urandom, $urandom});
  endfunction

  task automatic check();
    int j = eff - lat;
    bit rd = (j >= 0) && (kind_h[j] == 1);
    bit exp_drv = rd && out_en && !sleep;
    logic [W-1:0] exp_q = exp_drv ? exp_h[j] : '0;
    string t = (j >= 0) ? tag_h[j] : "R12";
    if (prev_frozen) t = "R11";
    if (!out_en)     t = "R9";
    if (sleep)       t = "R10";
    n_vec++;
    if (q_drive !== exp_drv || q !== exp_q) begin
      n_bad++;
      $display("FAIL %s: q_drive=%0b q=%h expected q_drive=%0b q=%h",
               t, q_drive, q, exp_drv, exp_q);
    end
  endtask

  // kind: 0 deselect, 1 read, 2 write, 3 advance
  task automatic issue(int kind, logic [AW-1:0] a, logic [NB-1:0] ben,
                       bit frz, bit slp, bit oe, string tag);
    int op, j, pick;
    logic [AW-1:0] ea;
    logic [W-1:0]  wd;
    @(negedge clk);
    check();
    clk_en = !frz; sleep = slp; out_en = oe; addr = a; bwe_n = ben;
    case (kind)
      0: begin
        adv = 1'b0; wr_en = 1'($urandom % 2); pick = int'($urandom % 3);
        ce_a_n = (pick == 0); ce_b = (pick != 1); ce_c_n = (pick == 2);
      end
      1, 2: begin
        adv = 1'b0; wr_en = (kind == 2); ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
      end
      default: begin   // R7: enables and wr_en random, must be ignored
        adv = 1'b1; wr_en = 1'($urandom % 2);
        ce_a_n = 1'($urandom % 2); ce_b = 1'($urandom % 2); ce_c_n = 1'($urandom % 2);
      end
    endcase
    j = eff - lat;
    wdata = (j >= 0 && kind_h[j] == 2) ? wdat_h[j] : rnd_word();
    prev_frozen = frz;
    if (!frz) begin
      op = 0; ea = a;
      if (slp) op = 0;
      else if (kind == 3) begin
        if (b_op != 0) begin
          b_cnt = b_cnt + 2'd1;
          ea = {b_base[AW-1:2], ref_low(b_base[1:0], b_cnt, burst_ilv)};
          op = b_op;
        end
      end else if (kind == 0) b_op = 0;
      else begin b_op = kind; b_base = a; b_cnt = '0; op = kind; end
      if (op == 1) exp_h[eff] = ref_mem[ea];
      if (op == 2) begin
        wd = rnd_word();
        wdat_h[eff] = wd;
        ref_mem[ea] = ref_merge(ref_mem[ea], wd, ben);
      end
      kind_h[eff] = op; tag_h[eff] = tag;
      if (eff < HMAX - 1) eff++;
    end
  endtask

  task automatic run_phase(bit pm, bit il, bit init_mem, int nrand);
    string mt = pm ? "R2" : "R3";
    int r;
    logic [NB-1:0] bn;
    repeat (3) issue(0, '0, '1, 0, 0, 1, "R6");
    @(negedge clk);
    rst_n = 1'b0; pipe_mode = pm; burst_ilv = il; lat = pm ? 2 : 1;
    eff = 0; b_op = 0; prev_frozen = 0;
    ce_a_n = 1'b1; adv = 1'b0; clk_en = 1'b1; sleep = 1'b0; out_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check();   // R12 reset state
    if (init_mem) for (int a = 0; a < DEPTH; a++) issue(2, AW'(a), '0, 0, 0, 1, mt);
    // R4 read right after write, and write between reads
    issue(2, 6'd5, 8'h00, 0, 0, 1, "R4"); issue(1, 6'd5, '1, 0, 0, 1, "R4");
    issue(1, 6'd7, '1, 0, 0, 1, "R4"); issue(2, 6'd7, 8'h0F, 0, 0, 1, "R4");
    issue(1, 6'd7, '1, 0, 0, 1, "R4");
    // R5 partial lanes
    issue(2, 6'd9, 8'hA5, 0, 0, 1, "R5"); issue(2, 6'd9, 8'hFE, 0, 0, 1, "R5");
    issue(1, 6'd9, '1, 0, 0, 1, "R5");
    // R8 write burst from low bits 2, read burst wraps past four beats
    issue(2, 6'd14, 8'h00, 0, 0, 1, "R8");
    repeat (3) issue(3, 6'd0, 8'h00, 0, 0, 1, "R8");
    issue(1, 6'd14, '1, 0, 0, 1, "R8");
    repeat (5) issue(3, 6'd33, '1, 0, 0, 1, "R7");
    // R10 sleep mid burst, then continue
    issue(1, 6'd13, '1, 0, 0, 1, "R8"); issue(3, 6'd0, '1, 0, 1, 1, "R10");
    issue(3, 6'd0, '1, 0, 0, 1, "R7"); issue(3, 6'd0, '1, 0, 0, 1, "R7");
    // R11 freeze between write and read
    issue(2, 6'd20, 8'h00, 0, 0, 1, "R11");
    issue(1, 6'd21, '1, 1, 0, 1, "R11"); issue(2, 6'd20, '0, 1, 0, 1, "R11");
    issue(1, 6'd20, '1, 0, 0, 1, "R11");
    // R6 deselects, then an advance that must do nothing (R7)
    repeat (3) issue(0, 6'd3, '0, 0, 0, 1, "R6");
    issue(3, 6'd3, '0, 0, 0, 1, "R7"); issue(1, 6'd3, '1, 0, 0, 1, mt);
    // R9 output enable low over a read slot
    issue(1, 6'd3, '1, 0, 0, 0, "R9"); issue(1, 6'd4, '1, 0, 0, 0, "R9");
    issue(0, 6'd4, '1, 0, 0, 0, "R9");
    for (int i = 0; i < nrand; i++) begin
      r = int'($urandom % 20);
      bn = ($urandom % 3 == 0) ? '0 : NB'($urandom);
      if (r < 2)       issue(0, AW'($urandom % 16), bn, 0, 0, ($urandom % 10) != 0, "R6");
      else if (r < 8)  issue(1, AW'($urandom % 16), bn, 0, 0, ($urandom % 10) != 0, mt);
      else if (r < 14) issue(2, AW'($urandom % 16), bn, 0, 0, ($urandom % 10) != 0, "R4");
      else if (r < 18) issue(3, AW'($urandom % 16), bn, 0, 0, ($urandom % 10) != 0, "R7");
      else if (r == 18) issue(int'($urandom % 4), AW'($urandom), bn, 1, 0, 1, "R11");
      else             issue(int'($urandom % 4), AW'($urandom), bn, 0, 1, 1, "R10");
    end
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    run_phase(1, 0, 1, 1200);
    run_phase(0, 1, 0, 1200);
    run_phase(1, 1, 0, 800);
    run_phase(0, 0, 0, 400);
    repeat (3) issue(0, '0, '1, 0, 0, 1, "R6");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule